// File: doc/BRIEF.md
# Banked Cross-Lane Scatter/Gather Router

This block moves 32-bit words between the 64 lanes of a vector. A request carries one word and one 6-bit lane index per lane, an active-lane mask and a direction bit. In scatter direction every active lane delivers its word to the lane its index names. In gather direction every active lane fetches the word held by the lane its index names. The router keeps nothing once a result has been delivered. It is meant to sit beside a vector datapath and perform data-dependent shuffles such as stream compaction.

Routing passes through 32 single-ported banks. A lane's bank is its index modulo 32, and each bank carries one access per cycle. Each cycle, every bank serves the lowest-numbered lane still waiting for it. A full vector with no bank overloaded therefore takes two rounds: the low half of the lanes, then the high half. Lanes that pile onto one bank are spread over further rounds. The input handshake is closed while rounds are running, and the finished vector is announced by a one-cycle pulse.

Top module: `lane_xbar`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid` is 0.
- R2: With `in_mode`=1 (gather), output lane i is the data word of lane idx[i] when both lane i and lane idx[i] are set in the mask. In every other case output lane i is 0.
- R3: With `in_mode`=0 (scatter), output lane d is the data word of the highest-numbered active lane whose index equals d. An output lane that no active lane targets is 0.
- R4: The bank of a lane is idx mod 32. Let N be the largest number of active lanes that share a bank, or 1 if that number is smaller than 1. Then `out_valid` is high exactly N cycles after the accepting edge. A full vector with no overloaded bank therefore completes in 2 cycles.
- R5: A request is accepted on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` stays 0 from the cycle after acceptance until the cycle in which `out_valid` is high.
- R6: `out_valid` is high for exactly one cycle per request, and `in_ready` is 1 in that cycle.
- R7: Scatter performs stream compaction. If each kept lane's index is the number of kept lanes below it, the kept words appear in order at output lanes 0 upward, and the remaining output lanes are 0.
- R8: Inputs presented while a request is in flight are ignored and do not change that request's result.
- Encodings: lane l's data is at `in_data[32*l +: 32]`, its index is at `in_idx[6*l +: 6]`, and its mask bit is `in_mask[l]`. Output lane l is at `out_data[32*l +: 32]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Router idle, request can be accepted |
| in_mode | input | 1 | 1 = gather, 0 = scatter |
| in_mask | input | 64 | Active lanes |
| in_idx | input | 384 | Per-lane 6-bit lane index |
| in_data | input | 2048 | Per-lane 32-bit word |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | 2048 | Permuted vector |

## Verification
A faulty grant or a faulty pending mask shows up at the ports in two ways. The result strobe arrives on the wrong cycle, which breaks the latency rule derived from the per-bank load. A lane is served twice or not at all, which leaves a wrong or zero word in the result of that same request. When the collision winner is wrong, the scatter result for that request holds a lower lane's word instead of the highest lane's word. Every request is therefore checked for its exact completion cycle as well as its full result. The sweeps cover light bank load (two rounds), moderate load (16 rounds) and a single bank carrying all 64 lanes (64 rounds).

// File: rtl/lane_xbar.sv
module lane_xbar #(
  parameter int LANES = 64,
  parameter int W     = 32,
  parameter int BANKS = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 in_mode,
  input  logic [LANES-1:0]     in_mask,
  input  logic [LANES*$clog2(LANES)-1:0] in_idx,
  input  logic [LANES*W-1:0]   in_data,
  output logic                 out_valid,
  output logic [LANES*W-1:0]   out_data
);
  localparam int IW = $clog2(LANES);
  localparam int BW = $clog2(BANKS);

  logic             busy_q, done_q, mode_q;
  logic [LANES-1:0] mask_q, pend_q, gnt, pend_nxt;
  logic [IW-1:0]    idx_q [LANES];
  logic [W-1:0]     dat_q [LANES];
  logic [W-1:0]     res_q [LANES];
  logic [W-1:0]     res_nxt [LANES];

  assign in_ready  = !busy_q;
  assign out_valid = done_q;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      gnt[l] = pend_q[l];
      for (int k = 0; k < LANES; k++)
        if (k < l && pend_q[k] && idx_q[k][BW-1:0] == idx_q[l][BW-1:0])
          gnt[l] = 1'b0;
    end
  end

  assign pend_nxt = pend_q & ~gnt;

  always_comb begin
    for (int l = 0; l < LANES; l++) res_nxt[l] = res_q[l];
    for (int l = 0; l < LANES; l++)
      if (gnt[l]) begin
        if (mode_q)
          res_nxt[l] = mask_q[idx_q[l]] ? dat_q[idx_q[l]] : '0;
        else
          res_nxt[idx_q[l]] = dat_q[l];
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      mode_q <= 1'b0;
      mask_q <= '0;
      pend_q <= '0;
      for (int l = 0; l < LANES; l++) begin
        res_q[l] <= '0;
        idx_q[l] <= '0;
        dat_q[l] <= '0;
      end
    end else begin
      done_q <= 1'b0;
      if (in_valid && !busy_q) begin
        busy_q <= 1'b1;
        mode_q <= in_mode;
        mask_q <= in_mask;
        pend_q <= in_mask;
        for (int l = 0; l < LANES; l++) begin
          idx_q[l] <= in_idx[l*IW +: IW];
          dat_q[l] <= in_data[l*W +: W];
          res_q[l] <= '0;
        end
      end else if (busy_q) begin
        pend_q <= pend_nxt;
        for (int l = 0; l < LANES; l++) res_q[l] <= res_nxt[l];
        if (pend_nxt == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_pack
    assign out_data[g*W +: W] = res_q[g];
  end
endmodule

module lane_xbar_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic out_valid
);
  // R5
  accept_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  // R4
  no_early_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !out_valid);
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  // R6
  done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready);
  // R5
  ready_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !out_valid) |=> (!in_ready || out_valid));
endmodule

bind lane_xbar lane_xbar_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .in_ready(in_ready), .out_valid(out_valid)
);

// File: tb/tb_lane_xbar.sv
`timescale 1ns/1ps
module tb_lane_xbar;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_mode = 1'b0;
  logic in_ready, out_valid;
  logic [63:0] in_mask = '0;
  logic [383:0] in_idx = '0;
  logic [2047:0] in_data = '0, out_data;

  lane_xbar dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_mask(in_mask), .in_idx(in_idx), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data));

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [31:0] d [64];
  logic [5:0]  ix [64];
  logic [63:0] m;
  logic [31:0] e [64];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic run(input bit mode, input bit noise, input string req);
    int cnt [32];
    int lat, cyc, bad_lane;
    bit rdy_ok;
    for (int b = 0; b < 32; b++) cnt[b] = 0;
    for (int l = 0; l < 64; l++) e[l] = '0;
    for (int l = 0; l < 64; l++) if (m[l]) cnt[ix[l] % 32]++;
    lat = 1;
    for (int b = 0; b < 32; b++) if (cnt[b] > lat) lat = cnt[b];
    if (mode) begin
      for (int i = 0; i < 64; i++) e[i] = (m[i] && m[ix[i]]) ? d[ix[i]] : 32'h0;
    end else begin
      for (int l = 0; l < 64; l++) if (m[l]) e[ix[l]] = d[l];
    end
    @(negedge clk);
    in_valid = 1'b1; in_mode = mode; in_mask = m;
    for (int l = 0; l < 64; l++) begin
      in_idx[l*6 +: 6] = ix[l];
      in_data[l*32 +: 32] = d[l];
    end
    @(negedge clk);
    in_valid = 1'b0;
    rdy_ok = !in_ready && !out_valid;
    if (noise && lat >= 2) begin
      in_valid = 1'b1; in_mode = !mode; in_mask = ~m;
      in_idx = ~in_idx; in_data = ~in_data;
    end
    cyc = 0;
    while (1) begin
      @(negedge clk);
      in_valid = 1'b0;
      cyc++;
      if (out_valid) break;
      if (in_ready) rdy_ok = 1'b0;
      if (cyc > 200) break;
    end
    chk(cyc <= 200, "R4", "watchdog", cyc, lat);
    chk(cyc == lat, "R4", "latency", cyc, lat);
    chk(rdy_ok, "R5", "ready low while busy", rdy_ok, 1);
    chk(in_ready, "R6", "ready with result", in_ready, 1);
    bad_lane = -1;
    for (int l = 63; l >= 0; l--) if (out_data[l*32 +: 32] !== e[l]) bad_lane = l;
    if (bad_lane >= 0)
      chk(0, req, $sformatf("lane %0d", bad_lane), out_data[bad_lane*32 +: 32], e[bad_lane]);
    else
      chk(1, req, "data", 0, 0);
    @(negedge clk);
    chk(!out_valid, "R6", "pulse width", out_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready === 1'b1, "R1", "reset ready", in_ready, 1);
    chk(out_valid === 1'b0, "R1", "reset valid", out_valid, 0);

    for (int l = 0; l < 64; l++) d[l] = 32'hC0DE_0000 + l * 32'h0101_0003 + 1;

    // R2 rotations, full mask, two rounds each
    m = '1;
    for (int k = 0; k < 64; k++) begin
      for (int l = 0; l < 64; l++) ix[l] = 6'((l + k) % 64);
      run(1'b1, 1'b0, "R2");
    end
    // R3 rotations and reversal by scatter
    for (int k = 0; k < 64; k += 5) begin
      for (int l = 0; l < 64; l++) ix[l] = 6'((l + k) % 64);
      run(1'b0, 1'b0, "R3");
    end
    for (int l = 0; l < 64; l++) ix[l] = 6'(63 - l);
    run(1'b0, 1'b0, "R3");

    // R4 all lanes on one bank (64 rounds), R8 noise during run
    for (int l = 0; l < 64; l++) ix[l] = 6'd5;
    run(1'b1, 1'b1, "R8");
    // R3 collision: highest lane wins
    for (int l = 0; l < 64; l++) ix[l] = 6'd7;
    run(1'b0, 1'b1, "R3");
    // R4 moderate load: 16 rounds
    for (int l = 0; l < 64; l++) ix[l] = 6'((l * 8) % 64);
    run(1'b1, 1'b0, "R4");
    run(1'b0, 1'b1, "R3");

    // R2 partial mask: inactive sources and lanes give 0
    for (int l = 0; l < 64; l++) begin
      m[l] = (l % 3) != 0;
      ix[l] = 6'((l * 5 + 1) % 64);
    end
    run(1'b1, 1'b0, "R2");
    run(1'b0, 1'b0, "R3");

    // R7 stream compaction
    begin
      int pos = 0;
      for (int l = 0; l < 64; l++) begin
        m[l] = ((l * 37) % 5) != 0;
        if (m[l]) begin ix[l] = 6'(pos); pos++; end
        else ix[l] = 6'(63 - l);
      end
      run(1'b0, 1'b0, "R7");
      pos = 0;
      for (int l = 0; l < 64; l++)
        if (m[l]) begin
          chk(out_data[pos*32 +: 32] == d[l], "R7", "compacted word", out_data[pos*32 +: 32], d[l]);
          pos++;
        end
      for (int j = pos; j < 64; j++)
        chk(out_data[j*32 +: 32] == 32'h0, "R7", "tail zero", out_data[j*32 +: 32], 0);
    end

    // R4 empty mask: one round, all zero
    m = '0;
    run(1'b1, 1'b0, "R4");
    run(1'b0, 1'b0, "R4");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R4 watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule